// File: doc/BRIEF.md
# Clock Configuration Boot Sequencer

This block runs once after power-up, before any system clock is allowed to run. It looks at which clock daughter-module is fitted (none, a coaxial-connector variant or an on-board PLL variant) and at a two-position switch code. From these it chooses a configuration for each clock chip and asks an external loader to program the chips one at a time: the RF reference buffer first, then the sample-clock buffer, then the PLL. When the PLL module is used it waits for the PLL reference clock to toggle before any load, and for PLL lock after the loads. It then releases the clock-manager reset and parks in a halt state until the next reset.

Before every load the sequencer reads two signature bytes from an external EEPROM. A matching signature tells the loader to take the configuration from EEPROM; otherwise it uses its built-in ROM. The serial protocols that write the chips and the memories themselves sit outside this block. It reaches them only through a load request/done port and a byte-read EEPROM port.

The load request is a valid/ready stream. `ld_valid` stays high with `ld_dev`, `ld_cfg` and `ld_src` held stable until a cycle with `ld_ready` high. That cycle accepts the request. The sequencer then does nothing until the loader returns a one-cycle `ld_done`. The loader can stall the sequencer for any number of cycles at either point.

Top module: `clkcfg_boot_seq`

## Requirements
- R1: While `rst` is high, `clkmgr_rst` is 1 and `boot_done`, `ld_valid` and `ee_rd` are 0.
- R2: A `mod_type` of 0 (none) or 3 (reserved) ignores the switches and loads configuration 0 into device 0 (RF reference), then device 1 (sample), then device 2 (PLL). It waits on no PLL flag and then finishes.
- R3: A `mod_type` of 1 (coaxial) with `sw_code` 00 loads configuration 0 into devices 0, 1 and 2, in that order.
- R4: A `mod_type` of 1 with `sw_code` 01, 10 or 11 loads configuration 1, 2 or 3 into device 0 and then device 1. Device 2 is never requested.
- R5: A `mod_type` of 2 (PLL) with `sw_code` 00 loads configuration 0 into devices 0, 1 and 2 and finishes. It does not wait for `refclk_active` or for `pll_locked`.
- R6: A `mod_type` of 2 with `sw_code` 01, 10 or 11 issues no EEPROM read and no load until `refclk_active` is 1. It then loads configuration 4, 5 or 6 into devices 0, 1 and 2, in that order.
- R7: In the R6 case, `boot_done` stays 0 and `clkmgr_rst` stays 1 after the last load until `pll_locked` is 1.
- R8: Before each load the block reads EEPROM address 15000 and then address 15001. Each read is a one-cycle `ee_rd` pulse answered by `ee_dvalid`. The request carries `ld_src`=1 exactly when the bytes returned are 0xA5 and then 0xCD, and `ld_src`=0 otherwise.
- R9: While `ld_valid` is high and `ld_ready` is low, the request and its fields hold stable. After acceptance no new EEPROM read or request starts before `ld_done`.
- R10: Finishing drops `clkmgr_rst` and raises `boot_done`. Both stay that way, with no further loads or EEPROM reads, until reset.
- R11: `state_code` reports the step in progress: 0 deciding, 1 waiting for reference clock, 2 starting signature read, 3 reading signature, 4 requesting, 5 awaiting done, 6 waiting for lock, 7 halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_type | input | 2 | Fitted clock module: 0 none, 1 coaxial, 2 PLL, 3 treated as none |
| sw_code | input | 2 | Switch code choosing configuration A/B/C or bypass |
| refclk_active | input | 1 | PLL reference clock seen toggling (already synchronised) |
| pll_locked | input | 1 | PLL lock flag (already synchronised) |
| ld_valid | output | 1 | Load request valid |
| ld_ready | input | 1 | Loader accepts the request |
| ld_dev | output | 2 | Target device: 0 RF reference, 1 sample, 2 PLL |
| ld_cfg | output | 3 | Configuration: 0 no-module, 1-3 coaxial A-C, 4-6 PLL A-C |
| ld_src | output | 1 | 1 = take configuration from EEPROM, 0 = built-in ROM |
| ld_done | input | 1 | One-cycle pulse: loader finished the accepted request |
| ee_rd | output | 1 | One-cycle EEPROM byte read strobe |
| ee_addr | output | 14 | EEPROM byte address |
| ee_dvalid | input | 1 | EEPROM read data valid, at least one cycle after `ee_rd` |
| ee_data | input | 8 | EEPROM read data |
| clkmgr_rst | output | 1 | Clock-manager reset, released on finishing |
| boot_done | output | 1 | Sequence finished, block halted |
| state_code | output | 3 | Current step code |

## Verification
The bench builds the block with its default parameters: a 14-bit EEPROM address, signature bytes 0xA5/0xCD at 15000/15001, a 2-bit device ID and a 3-bit configuration ID. This covers every device and configuration code and the top region of the address space where the signature lives. Ten runs, each preceded by a reset, cover every module type. Together they use every switch code, both signature outcomes, a corrupted second signature byte and loader ready delays from zero to three cycles. The PLL runs hold the reference and lock flags low for a while to show the sequencer stalls at the right step.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  localparam int DEV_W = 2;
  localparam int CFG_W = 3;
  localparam int ST_W  = 3;

  typedef enum logic [1:0] {
    MOD_NONE = 2'd0,
    MOD_COAX = 2'd1,
    MOD_PLL  = 2'd2,
    MOD_RSVD = 2'd3
  } mod_e;

  // device order is the load order
  localparam logic [DEV_W-1:0] DEV_RFREF = 2'd0;
  localparam logic [DEV_W-1:0] DEV_SAMP  = 2'd1;
  localparam logic [DEV_W-1:0] DEV_PLLC  = 2'd2;

  localparam logic [CFG_W-1:0] CFG_BARE      = 3'd0;
  localparam logic [CFG_W-1:0] CFG_COAX_BASE = 3'd0;
  localparam logic [CFG_W-1:0] CFG_PLL_BASE  = 3'd3;

  typedef enum logic [ST_W-1:0] {
    ST_DECIDE  = 3'd0,
    ST_REFWAIT = 3'd1,
    ST_SIGRD   = 3'd2,
    ST_SIGWT   = 3'd3,
    ST_REQ     = 3'd4,
    ST_WAIT    = 3'd5,
    ST_LOCK    = 3'd6,
    ST_HALT    = 3'd7
  } seq_st_e;

endpackage

// File: rtl/clkcfg_plan.sv
module clkcfg_plan
  import clkcfg_pkg::*;
(
  input  logic [1:0]       mod_type,
  input  logic [1:0]       sw_code,
  output logic [CFG_W-1:0] cfg_id,
  output logic [DEV_W-1:0] last_dev,
  output logic             wait_ref,
  output logic             wait_lock
);

  always_comb begin
    cfg_id    = CFG_BARE;
    last_dev  = DEV_PLLC;
    wait_ref  = 1'b0;
    wait_lock = 1'b0;
    if (sw_code != 2'b00) begin
      case (mod_e'(mod_type))
        MOD_COAX: begin
          cfg_id   = CFG_COAX_BASE + CFG_W'(sw_code);
          last_dev = DEV_SAMP;
        end
        MOD_PLL: begin
          cfg_id    = CFG_PLL_BASE + CFG_W'(sw_code);
          wait_ref  = 1'b1;
          wait_lock = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/clkcfg_sig_reader.sv
module clkcfg_sig_reader #(
  parameter int               EE_AW = 14,
  parameter int               EE_DW = 8,
  parameter int unsigned      ADDR0 = 15000,
  parameter int unsigned      ADDR1 = 15001,
  parameter logic [EE_DW-1:0] BYTE0 = 8'hA5,
  parameter logic [EE_DW-1:0] BYTE1 = 8'hCD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             ee_rd,
  output logic [EE_AW-1:0] ee_addr,
  input  logic             ee_dvalid,
  input  logic [EE_DW-1:0] ee_data,
  output logic             done,
  output logic             ok
);

  typedef enum logic [2:0] {RS_IDLE, RS_RD0, RS_W0, RS_RD1, RS_W1} rd_st_e;
  rd_st_e st_q;
  logic   first_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= RS_IDLE;
      done       <= 1'b0;
      ok         <= 1'b0;
      first_ok_q <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        RS_IDLE: if (start) st_q <= RS_RD0;
        RS_RD0:  st_q <= RS_W0;
        RS_W0: if (ee_dvalid) begin
          first_ok_q <= (ee_data == BYTE0);
          st_q       <= RS_RD1;
        end
        RS_RD1:  st_q <= RS_W1;
        RS_W1: if (ee_dvalid) begin
          ok   <= first_ok_q && (ee_data == BYTE1);
          done <= 1'b1;
          st_q <= RS_IDLE;
        end
        default: st_q <= RS_IDLE;
      endcase
    end
  end

  assign ee_rd   = (st_q == RS_RD0) || (st_q == RS_RD1);
  assign ee_addr = (st_q == RS_RD1) ? EE_AW'(ADDR1) : EE_AW'(ADDR0);

  // R8: each byte read is a single-cycle strobe
  a_r8_rd_single: assert property (@(posedge clk) disable iff (rst)
    ee_rd |=> !ee_rd);
  // R8: completion is a single pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/clkcfg_boot_seq.sv
module clkcfg_boot_seq
  import clkcfg_pkg::*;
#(
  parameter int               EE_AW     = 14,
  parameter int               EE_DW     = 8,
  parameter int unsigned      SIG_ADDR0 = 15000,
  parameter int unsigned      SIG_ADDR1 = 15001,
  parameter logic [EE_DW-1:0] SIG_BYTE0 = 8'hA5,
  parameter logic [EE_DW-1:0] SIG_BYTE1 = 8'hCD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mod_type,
  input  logic [1:0]       sw_code,
  input  logic             refclk_active,
  input  logic             pll_locked,
  output logic             ld_valid,
  input  logic             ld_ready,
  output logic [DEV_W-1:0] ld_dev,
  output logic [CFG_W-1:0] ld_cfg,
  output logic             ld_src,
  input  logic             ld_done,
  output logic             ee_rd,
  output logic [EE_AW-1:0] ee_addr,
  input  logic             ee_dvalid,
  input  logic [EE_DW-1:0] ee_data,
  output logic             clkmgr_rst,
  output logic             boot_done,
  output logic [ST_W-1:0]  state_code
);

  seq_st_e          st_q;
  logic [DEV_W-1:0] dev_q;
  logic [CFG_W-1:0] cfg_q;
  logic [DEV_W-1:0] last_q;
  logic             ref_q, lock_q, src_q;

  logic [CFG_W-1:0] plan_cfg;
  logic [DEV_W-1:0] plan_last;
  logic             plan_ref, plan_lock;
  logic             sig_start, sig_done, sig_ok;

  clkcfg_plan u_plan (
    .mod_type  (mod_type),
    .sw_code   (sw_code),
    .cfg_id    (plan_cfg),
    .last_dev  (plan_last),
    .wait_ref  (plan_ref),
    .wait_lock (plan_lock)
  );

  clkcfg_sig_reader #(
    .EE_AW (EE_AW),
    .EE_DW (EE_DW),
    .ADDR0 (SIG_ADDR0),
    .ADDR1 (SIG_ADDR1),
    .BYTE0 (SIG_BYTE0),
    .BYTE1 (SIG_BYTE1)
  ) u_sig (
    .clk       (clk),
    .rst       (rst),
    .start     (sig_start),
    .ee_rd     (ee_rd),
    .ee_addr   (ee_addr),
    .ee_dvalid (ee_dvalid),
    .ee_data   (ee_data),
    .done      (sig_done),
    .ok        (sig_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_DECIDE;
      dev_q  <= DEV_RFREF;
      cfg_q  <= CFG_BARE;
      last_q <= DEV_PLLC;
      ref_q  <= 1'b0;
      lock_q <= 1'b0;
      src_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_DECIDE: begin
          cfg_q  <= plan_cfg;
          last_q <= plan_last;
          ref_q  <= plan_ref;
          lock_q <= plan_lock;
          dev_q  <= DEV_RFREF;
          st_q   <= plan_ref ? ST_REFWAIT : ST_SIGRD;
        end
        ST_REFWAIT: if (refclk_active) st_q <= ST_SIGRD;
        ST_SIGRD:   st_q <= ST_SIGWT;
        ST_SIGWT: if (sig_done) begin
          src_q <= sig_ok;
          st_q  <= ST_REQ;
        end
        ST_REQ: if (ld_ready) st_q <= ST_WAIT;
        ST_WAIT: if (ld_done) begin
          if (dev_q == last_q) begin
            st_q <= lock_q ? ST_LOCK : ST_HALT;
          end else begin
            dev_q <= dev_q + 1'b1;
            st_q  <= ST_SIGRD;
          end
        end
        ST_LOCK: if (pll_locked) st_q <= ST_HALT;
        default: st_q <= ST_HALT;
      endcase
    end
  end

  assign sig_start  = (st_q == ST_SIGRD);
  assign ld_valid   = (st_q == ST_REQ);
  assign ld_dev     = dev_q;
  assign ld_cfg     = cfg_q;
  assign ld_src     = src_q;
  assign boot_done  = (st_q == ST_HALT);
  assign clkmgr_rst = (st_q != ST_HALT);
  assign state_code = st_q;

  // R9: a stalled request keeps its content
  a_r9_hold_request: assert property (@(posedge clk) disable iff (rst)
    ld_valid && !ld_ready |=> ld_valid && $stable(ld_dev) && $stable(ld_cfg) && $stable(ld_src));
  // R9: no read restarts while a load is outstanding
  a_r9_quiet_until_done: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT) && !ld_done |=> !ee_rd && !ld_valid);
  // R4: a device beyond the chosen plan is never requested
  a_r4_dev_in_plan: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> ld_dev <= last_q);
  // R6: the reference-clock wait holds until the flag rises
  a_r6_refwait_hold: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_REFWAIT) && !refclk_active |=> (st_q == ST_REFWAIT) && !ee_rd);
  // R7: PLL plans finish only after lock is reported
  a_r7_lock_before_done: assert property (@(posedge clk) disable iff (rst)
    $rose(boot_done) && lock_q |-> $past(pll_locked));
  // R10: the halt state is permanent
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    boot_done |=> boot_done && !clkmgr_rst && !ld_valid && !ee_rd);

endmodule

// File: tb/clkcfg_boot_seq_bench.sv
`timescale 1ns/1ps
module clkcfg_boot_seq_bench;

  typedef struct packed {
    logic [1:0] dev;
    logic [2:0] cfg;
    logic       src;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mod_type = 2'd0;
  logic [1:0]  sw_code = 2'd0;
  logic        refclk_active = 1'b0;
  logic        pll_locked = 1'b0;
  logic        ld_valid;
  logic        ld_ready = 1'b0;
  logic [1:0]  ld_dev;
  logic [2:0]  ld_cfg;
  logic        ld_src;
  logic        ld_done = 1'b0;
  logic        ee_rd;
  logic [13:0] ee_addr;
  logic        ee_dvalid = 1'b0;
  logic [7:0]  ee_data = 8'h00;
  logic        clkmgr_rst;
  logic        boot_done;
  logic [2:0]  state_code;

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  int    rdy_dly = 0;
  int    ee_reads = 0;
  int    loads_seen = 0;
  int    dones_given = 0;
  bit    sig_good = 1'b1;
  bit    sig_bad_second = 1'b0;
  bit    expect_second = 1'b0;
  string cur_tag = "R2";
  item_t exp_q[$];

  always #5 clk = ~clk;

  clkcfg_boot_seq u_clkcfg_boot_seq (
    .clk           (clk),
    .rst           (rst),
    .mod_type      (mod_type),
    .sw_code       (sw_code),
    .refclk_active (refclk_active),
    .pll_locked    (pll_locked),
    .ld_valid      (ld_valid),
    .ld_ready      (ld_ready),
    .ld_dev        (ld_dev),
    .ld_cfg        (ld_cfg),
    .ld_src        (ld_src),
    .ld_done       (ld_done),
    .ee_rd         (ee_rd),
    .ee_addr       (ee_addr),
    .ee_dvalid     (ee_dvalid),
    .ee_data       (ee_data),
    .clkmgr_rst    (clkmgr_rst),
    .boot_done     (boot_done),
    .state_code    (state_code)
  );

  task automatic check(input bit cond, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        finish_run();
      end
    end
  end

  // EEPROM model: answers each strobe one cycle later, checks R8 address order
  initial begin
    bit pend;
    bit second;
    pend = 1'b0;
    second = 1'b0;
    forever begin
      @(negedge clk);
      ee_dvalid = 1'b0;
      if (pend) begin
        ee_dvalid = 1'b1;
        if (!second) ee_data = sig_good ? 8'hA5 : 8'h5A;
        else         ee_data = (sig_good && !sig_bad_second) ? 8'hCD : 8'hCC;
        pend = 1'b0;
      end
      if (ee_rd && !rst) begin
        check(ee_addr == (expect_second ? 14'd15001 : 14'd15000), "R8",
              "signature address", ee_addr, expect_second ? 15001 : 15000);
        second = expect_second;
        expect_second = !expect_second;
        ee_reads++;
        pend = 1'b1;
      end
    end
  end

  // loader model and scoreboard monitor
  initial begin
    item_t got;
    item_t want;
    forever begin
      @(negedge clk);
      if (ld_valid && !rst) begin
        bit steady;
        got = '{dev: ld_dev, cfg: ld_cfg, src: ld_src};
        steady = 1'b1;
        for (int i = 0; i < rdy_dly; i++) begin
          @(negedge clk);
          if (!ld_valid || ld_dev != got.dev || ld_cfg != got.cfg || ld_src != got.src)
            steady = 1'b0;
        end
        check(steady, "R9", "request stable while stalled", steady, 1);
        ld_ready = 1'b1;
        loads_seen++;
        if (exp_q.size() == 0) begin
          check(1'b0, cur_tag, "unexpected load dev", got.dev, -1);
        end else begin
          want = exp_q.pop_front();
          check(got.dev == want.dev, cur_tag, "device order", got.dev, want.dev);
          check(got.cfg == want.cfg, cur_tag, "configuration", got.cfg, want.cfg);
          check(got.src == want.src, "R8", "source select", got.src, want.src);
        end
        @(negedge clk);
        ld_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!ld_valid && !ee_rd, "R9", "idle before done", ld_valid, 0);
        ld_done = 1'b1;
        dones_given++;
        @(negedge clk);
        ld_done = 1'b0;
      end
    end
  end

  task automatic push_expected(input logic [1:0] mt, input logic [1:0] sw, input bit src);
    if (mt == 2'd0 || mt == 2'd3 || sw == 2'd0) begin
      for (int d = 0; d < 3; d++) exp_q.push_back('{dev: 2'(d), cfg: 3'd0, src: src});
    end else if (mt == 2'd1) begin
      for (int d = 0; d < 2; d++) exp_q.push_back('{dev: 2'(d), cfg: {1'b0, sw}, src: src});
    end else begin
      for (int d = 0; d < 3; d++) exp_q.push_back('{dev: 2'(d), cfg: 3'd3 + {1'b0, sw}, src: src});
    end
  endtask

  task automatic run_case(input logic [1:0] mt, input logic [1:0] sw, input bit good,
                          input bit bad2, input int dly, input string tag);
    int nexp;
    bit pll_wait;
    int t;
    @(negedge clk);
    rst = 1'b1;
    mod_type = mt;
    sw_code = sw;
    refclk_active = 1'b0;
    pll_locked = 1'b0;
    sig_good = good;
    sig_bad_second = bad2;
    rdy_dly = dly;
    cur_tag = tag;
    exp_q.delete();
    repeat (3) @(negedge clk);
    check(clkmgr_rst && !boot_done && !ld_valid && !ee_rd, "R1", "reset outputs",
          {clkmgr_rst, boot_done, ld_valid, ee_rd}, 4'b1000);
    check(state_code == 3'd0, "R11", "state in reset", state_code, 0);
    expect_second = 1'b0;
    ee_reads = 0;
    loads_seen = 0;
    dones_given = 0;
    push_expected(mt, sw, good && !bad2);
    nexp = exp_q.size();
    pll_wait = (mt == 2'd2) && (sw != 2'd0);
    rst = 1'b0;
    if (pll_wait) begin
      repeat (20) @(negedge clk);
      check(loads_seen == 0 && ee_reads == 0 && !ld_valid, "R6", "activity before refclk",
            loads_seen + ee_reads, 0);
      check(state_code == 3'd1, "R11", "refclk wait code", state_code, 1);
      refclk_active = 1'b1;
    end
    t = 0;
    while (!(dones_given == nexp && !ld_done) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    if (pll_wait) begin
      repeat (15) @(negedge clk);
      check(!boot_done && clkmgr_rst, "R7", "finished before lock", boot_done, 0);
      check(state_code == 3'd6, "R11", "lock wait code", state_code, 6);
      pll_locked = 1'b1;
    end
    t = 0;
    while (!boot_done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check(boot_done && !clkmgr_rst, "R10", "release on finish",
          {boot_done, clkmgr_rst}, 2'b10);
    check(state_code == 3'd7, "R11", "halt code", state_code, 7);
    check(exp_q.size() == 0 && loads_seen == nexp, tag, "load count", loads_seen, nexp);
    check(ee_reads == 2 * nexp, "R8", "signature reads per load", ee_reads, 2 * nexp);
    refclk_active = 1'b0;
    pll_locked = 1'b0;
    for (int i = 0; i < 20; i++) @(negedge clk);
    check(boot_done && !clkmgr_rst && loads_seen == nexp && ee_reads == 2 * nexp, "R10",
          "halt is permanent", loads_seen, nexp);
  endtask

  initial begin
    run_case(2'd0, 2'b10, 1'b1, 1'b0, 0, "R2");
    run_case(2'd3, 2'b01, 1'b0, 1'b0, 1, "R2");
    run_case(2'd1, 2'b00, 1'b1, 1'b0, 2, "R3");
    run_case(2'd1, 2'b01, 1'b1, 1'b0, 3, "R4");
    run_case(2'd1, 2'b10, 1'b1, 1'b1, 0, "R4");
    run_case(2'd1, 2'b11, 1'b0, 1'b0, 1, "R4");
    run_case(2'd2, 2'b00, 1'b1, 1'b0, 2, "R5");
    run_case(2'd2, 2'b01, 1'b1, 1'b0, 0, "R6");
    run_case(2'd2, 2'b10, 1'b0, 1'b0, 3, "R6");
    run_case(2'd2, 2'b11, 1'b1, 1'b1, 1, "R6");
    finish_run();
  end

endmodule